// File: doc/BRIEF.md
# Byte-Accessed Free-Running Timer Core

A 16-bit up-counter that never stops while the device runs, read by an 8-bit processor through a small byte-wide register window. The counter is visible through two register pairs, a main pair and an alternate pair. Reading either high byte snapshots the low byte, so a high-then-low read gives a coherent 16-bit value even while the counter keeps moving.

Each wrap from all-ones to zero sets an overflow flag in the status byte. The flag clears only through a two-step handshake: a status read made while the flag is set, then an access of the main low byte. The alternate pair reads the counter without disturbing that handshake, so software can time intervals at any moment. An interrupt request is raised while the flag is set, the enable bit is on and the processor's global mask is off.

The count source is the internal clock divided by 2, 4 or 8, or edges of an external pin. The pin is resynchronised and its active edge is selectable. A halt input freezes the counter and the prescaler. Reset restores the count to FFFCh.

Top module: `tmr_free_run`

## Requirements
- R1: After reset the count is FFFCh, the status and control bytes read 00h and the interrupt request is low.
- R2: The control byte reads back as written. Its bits 2:1 pick the count source: 00 counts every 2nd clock, 01 every 4th clock, 10 every 8th clock, and 11 counts external edges. The counter advances by exactly one per count event.
- R3: Reading a high byte (address 0 main, address 2 alternate) captures the low byte. The next low-byte read (address 1 or 3) returns the captured value and ends the sequence. Further high-byte reads before that low-byte read do not replace the captured value.
- R4: A low-byte read with no sequence open returns the live low byte, through both the main and the alternate pair.
- R5: A wrap from FFFFh to 0000h sets the overflow flag, status bit 7 (address 4).
- R6: A read of the status byte while the flag is set, followed by a read or a write of the main low byte (address 1), clears the flag. A main low-byte access that was not armed this way leaves the flag set.
- R7: Reads of the alternate pair never clear the flag and do not cancel an armed clear.
- R8: A wrap that occurs after the arming status read cancels the arming, so the next main low-byte access leaves the flag set.
- R9: The interrupt output is high exactly when the flag is set, control bit 0 (enable) is 1 and the mask input is 0. Otherwise the request stays pending.
- R10: With source 11, control bit 3 = 1 counts rising edges of the external pin and bit 3 = 0 counts falling edges. The pin is first sampled on the falling clock edge, and edges are at least four clocks apart.
- R11: While halt is high, the counter and the prescaler hold their values. After halt drops, counting resumes from the held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| ext_clk_in | input | 1 | External count pin, asynchronous |
| halt_in | input | 1 | Freeze counting |
| cpu_imask | input | 1 | Processor global interrupt mask |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default 8-bit byte and the FFFCh reset value. Because that reset value sits four counts below the wrap, every prescaler setting reaches an overflow within a few dozen clocks. The bench sweeps all three divisors and compares every coherent and live read against an arithmetic count of running edges. A second full wrap at divide-by-2 brings the cancelled-arming case within reach. The external source wraps after four edges, so both edge polarities and the write-clear path are covered in short runs.

// File: rtl/tmr_pkg.sv
// Shared constants for the free-running timer: register addresses,
// count-source encodings and bit positions inside the status and
// control bytes. Assumes a byte of at least 8 bits.
package tmr_pkg;

    typedef enum logic [2:0] {
        RA_MAIN_HI = 3'd0,
        RA_MAIN_LO = 3'd1,
        RA_ALT_HI  = 3'd2,
        RA_ALT_LO  = 3'd3,
        RA_STATUS  = 3'd4,
        RA_CTRL    = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        CS_DIV2 = 2'd0,
        CS_DIV4 = 2'd1,
        CS_DIV8 = 2'd2,
        CS_EXT  = 2'd3
    } clk_src_e;

    localparam int STAT_OVF_BIT  = 7;
    localparam int CTRL_IE_BIT   = 0;
    localparam int CTRL_SEL_LSB  = 1;
    localparam int CTRL_EDGE_BIT = 3;
    localparam int PRE_STAGES    = 3;

endpackage

// File: rtl/tmr_tick_gen.sv
// Count-enable generator. Runs a free binary prescaler, derives the
// divide-by-2/4/8 strobes, resynchronises the external pin (first stage
// on the falling clock edge) and picks one source. Assumes external
// active edges are at least four clocks apart. Halt freezes the
// prescaler and blocks every count event.
module tmr_tick_gen
    import tmr_pkg::*;
#(
    parameter int PRE_W = PRE_STAGES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt,
    input  logic [1:0] clk_sel,
    input  logic       edge_rise,
    input  logic       ext_pin,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] div_tick;
    logic             sync_n_q;
    logic             sync_p_q;
    logic             prev_q;
    logic             ext_evt;
    logic             int_tick;

    // Prescaler: advances every clock unless halted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (!halt)
            pre_q <= pre_q + 1'b1;
    end

    // One strobe per power-of-two divisor: all low bits of the prescaler set.
    for (genvar g = 0; g < PRE_W; g++) begin : g_div
        assign div_tick[g] = &pre_q[g:0];
    end

    // First resync stage, clocked on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n)
            sync_n_q <= 1'b0;
        else
            sync_n_q <= ext_pin;
    end

    // Second resync stage and edge-history register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_p_q <= 1'b0;
            prev_q   <= 1'b0;
        end else begin
            sync_p_q <= sync_n_q;
            prev_q   <= sync_p_q;
        end
    end

    // Active-edge detection with polarity select.
    always_comb begin
        if (edge_rise)
            ext_evt = sync_p_q & ~prev_q;
        else
            ext_evt = ~sync_p_q & prev_q;
    end

    // Internal divisor select.
    always_comb begin
        case (clk_src_e'(clk_sel))
            CS_DIV2: int_tick = div_tick[0];
            CS_DIV4: int_tick = div_tick[1];
            CS_DIV8: int_tick = div_tick[2];
            default: int_tick = 1'b0;
        endcase
    end

    // Final count enable.
    always_comb begin
        if (halt)
            tick = 1'b0;
        else if (clk_src_e'(clk_sel) == CS_EXT)
            tick = ext_evt;
        else
            tick = int_tick;
    end

endmodule

// File: rtl/tmr_count_core.sv
// Counter and overflow flag. Advances by one on each tick. A wrap sets
// the flag; a status read seen while the flag is set arms the clear,
// and the next main low-byte access clears it. A wrap after arming
// disarms so that the new overflow is kept.
module tmr_count_core #(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             stat_rd,
    input  logic             main_lo_acc,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q
);

    logic armed_q;
    logic wrap;

    assign wrap = tick & (&cnt_q);

    // Up-counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= RST_VAL;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // Overflow flag: set on wrap, cleared by an armed main low-byte access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (wrap)
            ovf_q <= 1'b1;
        else if (armed_q && main_lo_acc)
            ovf_q <= 1'b0;
    end

    // Clear arming: set by a status read of a set flag, dropped by a wrap or the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (wrap)
            armed_q <= 1'b0;
        else if (stat_rd && ovf_q)
            armed_q <= 1'b1;
        else if (main_lo_acc)
            armed_q <= 1'b0;
    end

endmodule

// File: rtl/tmr_bus_regs.sv
// Byte register window: read mux, control byte, and the shared low-byte
// snapshot that makes high-then-low reads coherent on either pair.
// Produces the status-read and main-low-access strobes for the flag
// handshake. Assumes one access per strobe cycle.
module tmr_bus_regs
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ovf,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ovf_ie,
    output logic [1:0]        clk_sel,
    output logic              edge_rise,
    output logic              stat_rd,
    output logic              main_lo_acc
);

    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] lo_buf_q;
    logic              held_q;
    logic              hi_rd;
    logic              lo_rd;
    logic [BYTE_W-1:0] stat_byte;
    logic [BYTE_W-1:0] lo_view;

    assign hi_rd       = rd_en && (addr == RA_MAIN_HI || addr == RA_ALT_HI);
    assign lo_rd       = rd_en && (addr == RA_MAIN_LO || addr == RA_ALT_LO);
    assign stat_rd     = rd_en && (addr == RA_STATUS);
    assign main_lo_acc = (rd_en || wr_en) && (addr == RA_MAIN_LO);

    assign ovf_ie    = ctrl_q[CTRL_IE_BIT];
    assign clk_sel   = ctrl_q[CTRL_SEL_LSB +: 2];
    assign edge_rise = ctrl_q[CTRL_EDGE_BIT];

    // Control byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && addr == RA_CTRL)
            ctrl_q <= wr_data;
    end

    // Low-byte snapshot: taken on the first high read, released by a low read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_buf_q <= '0;
            held_q   <= 1'b0;
        end else if (lo_rd) begin
            held_q <= 1'b0;
        end else if (hi_rd && !held_q) begin
            lo_buf_q <= cnt[BYTE_W-1:0];
            held_q   <= 1'b1;
        end
    end

    // Status byte assembly.
    always_comb begin
        stat_byte               = '0;
        stat_byte[STAT_OVF_BIT] = ovf;
    end

    assign lo_view = held_q ? lo_buf_q : cnt[BYTE_W-1:0];

    // Read data mux.
    always_comb begin
        case (reg_addr_e'(addr))
            RA_MAIN_HI, RA_ALT_HI: rd_data = cnt[CNT_W-1:BYTE_W];
            RA_MAIN_LO, RA_ALT_LO: rd_data = lo_view;
            RA_STATUS:             rd_data = stat_byte;
            RA_CTRL:               rd_data = ctrl_q;
            default:               rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tmr_free_run.sv
// Top of the free-running timer: ties the count-enable generator, the
// counter with its overflow handshake and the byte register window
// together, and gates the interrupt request.
module tmr_free_run #(
    parameter int                 BYTE_W  = 8,
    parameter logic [2*BYTE_W-1:0] RST_VAL = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_clk_in,
    input  logic              halt_in,
    input  logic              cpu_imask,
    output logic              ovf_irq
);

    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             tick;
    logic             ovf_ie;
    logic [1:0]       clk_sel;
    logic             edge_rise;
    logic             stat_rd;
    logic             main_lo_acc;

    tmr_tick_gen u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt_in),
        .clk_sel   (clk_sel),
        .edge_rise (edge_rise),
        .ext_pin   (ext_clk_in),
        .tick      (tick)
    );

    tmr_count_core #(
        .CNT_W   (CNT_W),
        .RST_VAL (RST_VAL)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .stat_rd     (stat_rd),
        .main_lo_acc (main_lo_acc),
        .cnt_q       (cnt_q),
        .ovf_q       (ovf_q)
    );

    tmr_bus_regs #(
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (bus_addr),
        .rd_en       (bus_rd),
        .wr_en       (bus_wr),
        .wr_data     (bus_wdata),
        .cnt         (cnt_q),
        .ovf         (ovf_q),
        .rd_data     (bus_rdata),
        .ovf_ie      (ovf_ie),
        .clk_sel     (clk_sel),
        .edge_rise   (edge_rise),
        .stat_rd     (stat_rd),
        .main_lo_acc (main_lo_acc)
    );

    // Interrupt request: flag gated by enable and the global mask.
    assign ovf_irq = ovf_q & ovf_ie & ~cpu_imask;

endmodule

// File: rtl/tmr_free_run_chk.sv
// Property checker for the free-running timer, attached by bind.
// Watches the counter, flag, halt and bus strobes over time.
module tmr_free_run_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt_in,
    input logic [2:0]       bus_addr,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic             cpu_imask,
    input logic             ovf_irq,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_q
);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halt_in |=> $stable(cnt_q)); // R11

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == {CNT_W{1'b1}} && cnt_q == '0) |-> ovf_q); // R5

    AST_FLAG_CLEAR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_q) |-> ($past(bus_addr) == RA_MAIN_LO && ($past(bus_rd) || $past(bus_wr)))); // R6 R7

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> ovf_q); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_imask |-> !ovf_irq); // R9

endmodule

bind tmr_free_run tmr_free_run_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_in   (halt_in),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .cpu_imask (cpu_imask),
    .ovf_irq   (ovf_irq),
    .cnt_q     (cnt_q),
    .ovf_q     (ovf_q)
);

// File: tb/tmr_free_run_tb_top.sv
`timescale 1ns/1ps
module tmr_free_run_tb_top;

    localparam logic [15:0] RST = 16'hFFFC;
    localparam logic [2:0] A_MHI = 3'd0, A_MLO = 3'd1, A_AHI = 3'd2,
                           A_ALO = 3'd3, A_STA = 3'd4, A_CTL = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ext = 1'b0;
    logic       halt = 1'b1;
    logic       imask = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int unsigned run_edges = 0;

    tmr_free_run dut_i (
        .clk (clk), .rst_n (rst_n), .bus_addr (addr), .bus_rd (rd),
        .bus_wr (wr), .bus_wdata (wdata), .bus_rdata (rdata),
        .ext_clk_in (ext), .halt_in (halt), .cpu_imask (imask), .ovf_irq (irq)
    );

    always #2.5 clk = ~clk;

    // Count of edges on which the timer may advance.
    always @(posedge clk) begin
        if (!rst_n) run_edges <= 0;
        else if (!halt) run_edges <= run_edges + 1;
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] v, output int unsigned k);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1;
        v = rdata; k = run_edges;
        @(posedge clk);
        #1 rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic read16(input logic [2:0] hi_a, output logic [15:0] v, output int unsigned k);
        logic [7:0] h, l;
        int unsigned kk;
        bus_read(hi_a, h, k);
        bus_read(hi_a + 3'd1, l, kk);
        v = {h, l};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; halt = 1'b1; rd = 1'b0; wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic release_halt();
        @(negedge clk);
        halt = 1'b0;
    endtask

    function automatic logic [15:0] exp_cnt(int unsigned k, int sel);
        return 16'(RST + k / (2 << sel));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  v8, v8b;
        logic [15:0] v16;
        int unsigned k, k2;

        // R1: reset state
        do_reset();
        bus_read(A_STA, v8, k); check("R1", "status", v8, 8'h00);
        bus_read(A_CTL, v8, k); check("R1", "ctrl", v8, 8'h00);
        read16(A_MHI, v16, k);  check("R1", "count", v16, RST);
        #1 check("R1", "irq", irq, 1'b0);

        // R2/R3/R4/R5: sweep over the three divisors
        for (int s = 0; s < 3; s++) begin
            do_reset();
            bus_write(A_CTL, 8'(s << 1));
            bus_read(A_CTL, v8, k); check("R2", "ctrl readback", v8, 32'(s << 1));
            release_halt();
            for (int j = 0; j < 8; j++) begin
                repeat (j * 3 + 1) @(posedge clk);
                read16((j % 2 == 0) ? A_MHI : A_AHI, v16, k);
                check("R3", "coherent read", v16, exp_cnt(k, s));
                bus_read((j % 2 == 0) ? A_MLO : A_ALO, v8, k);
                check("R4", "live low byte", v8, {24'h0, exp_cnt(k, s)[7:0]});
            end
            // R3: repeated high reads keep the first snapshot
            bus_read(A_MHI, v8, k);
            repeat (9) @(posedge clk);
            bus_read(A_AHI, v8b, k2);
            check("R3", "second high read", v8b, {24'h0, exp_cnt(k2, s)[15:8]});
            repeat (5) @(posedge clk);
            bus_read(A_MLO, v8b, k2);
            check("R3", "held low byte", v8b, {24'h0, exp_cnt(k, s)[7:0]});
            // R5: wrap happened after 4*divisor running edges
            bus_read(A_STA, v8, k);
            check("R5", "flag after wrap", v8, (k >= 32'(4 * (2 << s))) ? 8'h80 : 8'h00);
        end

        // R11: halt freezes and resume continues from held count
        do_reset();
        bus_write(A_CTL, 8'h02);
        release_halt();
        repeat (20) @(posedge clk);
        @(negedge clk) halt = 1'b1;
        read16(A_MHI, v16, k);
        check("R11", "count at halt", v16, exp_cnt(k, 1));
        repeat (30) @(posedge clk);
        read16(A_AHI, v16, k2);
        check("R11", "count held", v16, exp_cnt(k, 1));
        release_halt();
        repeat (13) @(posedge clk);
        read16(A_MHI, v16, k);
        check("R11", "count resumed", v16, exp_cnt(k, 1));

        // R9/R6/R7/R8: flag handshake and interrupt gating at divide-by-2
        do_reset();
        bus_write(A_CTL, 8'h01);
        release_halt();
        while (run_edges < 10) @(posedge clk);
        @(negedge clk); #1;
        check("R9", "irq enabled", irq, 1'b1);
        imask = 1'b1; #1;
        check("R9", "irq masked", irq, 1'b0);
        imask = 1'b0;
        bus_write(A_CTL, 8'h00); #1;
        check("R9", "irq disabled", irq, 1'b0);
        bus_write(A_CTL, 8'h01); #1;
        check("R9", "irq pending returns", irq, 1'b1);
        bus_read(A_MLO, v8, k); #1;
        check("R6", "unarmed low read keeps flag", irq, 1'b1);
        bus_read(A_STA, v8, k);
        check("R5", "status flag", v8, 8'h80);
        bus_read(A_AHI, v8, k);
        bus_read(A_ALO, v8, k); #1;
        check("R7", "alternate reads keep flag", irq, 1'b1);
        while (run_edges < 8 + 131072 + 4) @(posedge clk);
        bus_write(A_MLO, 8'h00); #1;
        check("R8", "wrap after arming keeps flag", irq, 1'b1);
        bus_read(A_STA, v8, k);
        bus_read(A_MLO, v8, k); #1;
        check("R6", "armed low read clears", irq, 1'b0);
        bus_read(A_STA, v8, k);
        check("R6", "status after clear", v8, 8'h00);

        // R10: external rising edges, four of them wrap the count
        do_reset();
        ext = 1'b0;
        bus_write(A_CTL, 8'h0F);
        release_halt();
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1 ext = 1'b1;
            repeat (4) @(posedge clk);
            #1 ext = 1'b0;
            repeat (3) @(posedge clk);
        end
        repeat (6) @(posedge clk);
        read16(A_MHI, v16, k);
        check("R10", "rising edge count", v16, 16'h0000);
        #1 check("R10", "wrap from external", irq, 1'b1);
        bus_read(A_STA, v8, k);
        bus_write(A_MLO, 8'h5A); #1;
        check("R6", "armed low write clears", irq, 1'b0);

        // R10: external falling edges
        do_reset();
        @(posedge clk); #1 ext = 1'b1;
        bus_write(A_CTL, 8'h07);
        repeat (5) @(posedge clk);
        release_halt();
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1 ext = 1'b0;
            repeat (4) @(posedge clk);
            #1 ext = 1'b1;
            repeat (3) @(posedge clk);
        end
        repeat (6) @(posedge clk);
        read16(A_AHI, v16, k);
        check("R10", "falling edge count", v16, 16'hFFFF);
        #1 check("R10", "no wrap yet", irq, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule